// File: doc/BRIEF.md
# MDIO Management Frame Master

This block lets software reach PHY management registers over a two-wire management bus. Software programs a control word that turns the block on and chooses how far the system clock is divided to form the management clock. It then writes a single command word holding a start flag, the transfer direction, a PHY address, a register address and, for writes, sixteen bits of data. The block sends the complete management frame and, for reads, captures the returned data and notes whether a PHY answered.

While a transfer is in progress the start flag reads back as one, and it drops by itself when the transfer is over. Software therefore only has to poll the command word. Each transfer takes a fixed 88 management clock periods: a run of 32 ones, the 32-bit frame, and 24 trailing periods in which the data line is left released so the bus can settle. The data line is split into output, output-enable and input signals, which a pad outside the block combines. A read-only flag in the control word shows when the block is both switched off and free.

Top module: `mgmt_mdio_master`

## Requirements
- R1: After reset the control word (word address 0) reads 0x8000_00FF: idle flag set, enable clear, divider 0x00FF. The command word (word address 1) reads 0. The management clock and the data-line output enable are both low.
- R2: Control word layout: bit 31 is the read-only idle flag, bit 30 is enable, and bits 15:0 are the divider. The idle flag reads 1 exactly when enable is 0 and no transfer is pending. Writes to bit 31 have no effect.
- R3: During a transfer the management clock period is D+1 system clock cycles, where D is the divider (a divider of 0 acts as 1). The clock is low at the start of every period and is held low while no transfer runs. The divider in use is captured when the transfer starts, so control writes made during a transfer do not change the transfer's timing.
- R4: Command word layout: bit 31 is GO, bit 30 selects write (1) or read (0), bit 29 is the read-only ACK, bits 25:21 hold the register address, bits 20:16 hold the PHY address and bits 15:0 hold the data. The block first drives 32 ones. It then sends, most significant bit first: start 01, opcode 10 for a read or 01 for a write, the PHY address, the register address, the turnaround bits 10 (writes only) and the 16 data bits. Each bit is changed on the falling edge of the management clock and is valid at the rising edge.
- R5: On a read, the output enable is low from the first turnaround bit to the end of the transfer. The data input is sampled on rising clock edges. ACK reads 1 only if the second turnaround bit was sampled low. Bits 15:0 return the 16 bits sampled after the turnaround bits, so an absent PHY (line pulled high) returns 0xFFFF with ACK 0.
- R6: A transfer lasts 88 management clock periods, including 24 trailing released periods. GO reads 0 starting 88*(D+1)+1 cycles after the clock edge that accepted the command, and the read data and ACK are already valid in that cycle.
- R7: A command with GO set, written while enable is 0, does not start. GO stays 0, no management clock edge occurs, and the other command fields are still stored.
- R8: Any write to the command word while GO reads 1 is ignored, including its fields.
- R9: On a write transfer the output enable is high for all 64 preamble and frame bits and low during the trailing periods. After completion ACK reads 0 and the data field keeps the written value.
- R10: Clearing enable during a transfer does not abort it. The idle flag stays 0 until GO drops, then reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address (0 control, 1 command) |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line value seen at the pad |

## Verification
A period counter or bit index that is off by one moves a whole transfer out of alignment. It shows up within the first transfer as a wrong number of rising clock edges, a spacing between rising edges other than D+1 cycles, or GO dropping on a cycle other than 88*(D+1)+1. A frame word that is latched wrongly, or a slip in the turnaround position, shows up at the very next rising edge as a wrong driven bit or enable value. In a read it also corrupts ACK and the returned data, which software sees as soon as GO drops. Faults in the start guard (disabled block or busy command word) show at once as GO set, clock edges present, or fields changed in the command word read back a few cycles later.

// File: rtl/mgmt_mdio_pkg.sv
package mgmt_mdio_pkg;

    localparam int FRAME_BITS = 32;   // start..data
    localparam int TA_POS     = 14;   // index of first turnaround bit in the frame
    localparam int DIV_W      = 16;

    typedef struct packed {
        logic             go;
        logic             wr;
        logic             ack;
        logic [2:0]       rsvd;
        logic [4:0]       regad;
        logic [4:0]       phyad;
        logic [15:0]      data;
    } acc_word_t;

    typedef struct packed {
        logic             idle;
        logic             en;
        logic [13:0]      rsvd;
        logic [DIV_W-1:0] div;
    } ctl_word_t;

    typedef struct packed {
        logic        wr;
        logic [4:0]  phyad;
        logic [4:0]  regad;
        logic [15:0] data;
    } cmd_t;

    typedef struct packed {
        logic        ack;
        logic [15:0] data;
    } rsp_t;

    typedef struct packed {
        logic oe;
        logic o;
    } pin_t;

    // 32-bit frame, sent MSB first
    function automatic logic [31:0] frame_word(cmd_t c);
        return {2'b01, (c.wr ? 2'b01 : 2'b10), c.phyad, c.regad, 2'b10, c.data};
    endfunction

    // Line drive for period k of a transfer
    function automatic pin_t pin_for(int k, int pre, logic rd, logic [31:0] fw);
        pin_t p;
        int   j;
        p = '0;
        j = k - pre;
        if (k < pre) begin
            p.oe = 1'b1;
            p.o  = 1'b1;
        end else if (j < FRAME_BITS) begin
            if (!(rd && j >= TA_POS)) begin
                p.oe = 1'b1;
                p.o  = fw[5'(31 - j)];
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/mgmt_mdio_clkgen.sv
module mgmt_mdio_clkgen
    import mgmt_mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W:0]   lo;
    logic [DIV_W:0]   nxt;
    logic             mdc_q;

    always_comb begin
        lo   = ({1'b0, div_q} + 1'b1) >> 1;
        nxt  = {1'b0, cnt_q} + 1'b1;
        fall = run && (cnt_q == div_q);
        rise = run && !fall && (nxt == lo);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= DIV_W'(1);
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (start) begin
            div_q <= (div_in == '0) ? DIV_W'(1) : div_in;
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (run) begin
            cnt_q <= fall ? '0 : cnt_q + 1'b1;
            if (fall)      mdc_q <= 1'b0;
            else if (rise) mdc_q <= 1'b1;
        end else begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end
    end

    assign mdc = mdc_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> cnt_q <= div_q);                                  // R3
    AST_DIV_HELD: assert property (@(posedge clk) disable iff (rst)
        run && $past(run) |-> $stable(div_q));                    // R3

endmodule

// File: rtl/mgmt_mdio_engine.sv
module mgmt_mdio_engine
    import mgmt_mdio_pkg::*;
#(
    parameter int PRE_LEN   = 32,
    parameter int YIELD_LEN = 24
)(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  cmd_t cmd,
    input  logic rise,
    input  logic fall,
    input  logic mdio_i,
    output logic busy,
    output logic done,
    output rsp_t rsp,
    output logic mdio_o,
    output logic mdio_oe
);
    localparam int TOTAL = PRE_LEN + FRAME_BITS + YIELD_LEN;
    localparam int IDX_W = $clog2(TOTAL);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);
    localparam logic [IDX_W-1:0] TA1_IDX  = IDX_W'(PRE_LEN + TA_POS);
    localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(PRE_LEN + TA_POS + 1);
    localparam logic [IDX_W-1:0] D0_IDX   = IDX_W'(PRE_LEN + TA_POS + 2);
    localparam logic [IDX_W-1:0] DN_IDX   = IDX_W'(PRE_LEN + FRAME_BITS - 1);

    logic             busy_q, done_q, rd_q, ack_q;
    logic [IDX_W-1:0] kidx;
    logic [31:0]      fw_q;
    logic [15:0]      sh_q;
    pin_t             pin_q;
    logic [31:0]      fw_new;

    assign fw_new = frame_word(cmd);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            rd_q   <= 1'b0;
            ack_q  <= 1'b0;
            kidx   <= '0;
            fw_q   <= '0;
            sh_q   <= '0;
            pin_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                kidx   <= '0;
                fw_q   <= fw_new;
                rd_q   <= !cmd.wr;
                pin_q  <= pin_for(0, PRE_LEN, !cmd.wr, fw_new);
                ack_q  <= 1'b0;
                sh_q   <= '0;
            end else if (busy_q) begin
                if (fall) begin
                    if (kidx == LAST_IDX) begin
                        busy_q <= 1'b0;
                        pin_q  <= '0;
                        done_q <= 1'b1;
                    end else begin
                        kidx  <= kidx + 1'b1;
                        pin_q <= pin_for(int'(kidx) + 1, PRE_LEN, rd_q, fw_q);
                    end
                end
                if (rise && rd_q) begin
                    if (kidx == TA2_IDX) ack_q <= !mdio_i;
                    if (kidx >= D0_IDX && kidx <= DN_IDX) sh_q <= {sh_q[14:0], mdio_i};
                end
            end
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign rsp.ack  = ack_q;
    assign rsp.data = sh_q;
    assign mdio_o   = pin_q.o;
    assign mdio_oe  = pin_q.oe;

    AST_START_FREE: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);                                       // R8
    AST_LINE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !pin_q.oe);                                   // R5
    AST_READ_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
        busy_q && rd_q && (kidx >= TA1_IDX) |-> !pin_q.oe);       // R5

endmodule

// File: rtl/mgmt_mdio_regs.sv
module mgmt_mdio_regs
    import mgmt_mdio_pkg::*;
#(
    parameter int               ADDR_W  = 2,
    parameter logic [DIV_W-1:0] DIV_RST = 16'h00FF
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              done,
    input  rsp_t              rsp,
    output logic              start,
    output cmd_t              cmd,
    output logic [DIV_W-1:0]  div
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ACC_ADDR = ADDR_W'(1);

    logic             en_q, go_q, wr_q, ack_q;
    logic [DIV_W-1:0] div_q;
    logic [4:0]       regad_q, phyad_q;
    logic [15:0]      data_q;
    acc_word_t        w_acc, r_acc;
    ctl_word_t        w_ctl, r_ctl;
    logic             acc_wr, unused_wbits;

    assign w_acc  = acc_word_t'(wdata);
    assign w_ctl  = ctl_word_t'(wdata);
    assign acc_wr = we && (addr == ACC_ADDR) && !go_q;
    assign start  = acc_wr && w_acc.go && en_q;
    assign unused_wbits = ^{w_acc.ack, w_acc.rsvd, w_ctl.idle, w_ctl.rsvd};

    always_comb begin
        cmd.wr    = w_acc.wr;
        cmd.phyad = w_acc.phyad;
        cmd.regad = w_acc.regad;
        cmd.data  = w_acc.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            div_q   <= DIV_RST;
            go_q    <= 1'b0;
            wr_q    <= 1'b0;
            ack_q   <= 1'b0;
            regad_q <= '0;
            phyad_q <= '0;
            data_q  <= '0;
        end else begin
            if (we && addr == CTL_ADDR) begin
                en_q  <= w_ctl.en;
                div_q <= w_ctl.div;
            end
            if (acc_wr) begin
                wr_q    <= w_acc.wr;
                regad_q <= w_acc.regad;
                phyad_q <= w_acc.phyad;
                data_q  <= w_acc.data;
                if (start) begin
                    go_q  <= 1'b1;
                    ack_q <= 1'b0;
                end
            end
            if (done) begin
                go_q <= 1'b0;
                if (!wr_q) begin
                    data_q <= rsp.data;
                    ack_q  <= rsp.ack;
                end
            end
        end
    end

    always_comb begin
        r_ctl      = '0;
        r_ctl.idle = !en_q && !go_q;
        r_ctl.en   = en_q;
        r_ctl.div  = div_q;
        r_acc       = '0;
        r_acc.go    = go_q;
        r_acc.wr    = wr_q;
        r_acc.ack   = ack_q;
        r_acc.regad = regad_q;
        r_acc.phyad = phyad_q;
        r_acc.data  = data_q;
        case (addr)
            CTL_ADDR: rdata = r_ctl;
            ACC_ADDR: rdata = r_acc;
            default:  rdata = '0;
        endcase
    end

    assign div = div_q;

    AST_DONE_WHILE_GO: assert property (@(posedge clk) disable iff (rst)
        done |-> go_q);                                           // R6
    AST_GO_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(go_q) |-> $past(en_q));                             // R7
    AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        go_q && $past(go_q) |-> $stable({wr_q, regad_q, phyad_q})); // R8

endmodule

// File: rtl/mgmt_mdio_master.sv
module mgmt_mdio_master
    import mgmt_mdio_pkg::*;
#(
    parameter int               ADDR_W    = 2,
    parameter int               PRE_LEN   = 32,
    parameter int               YIELD_LEN = 24,
    parameter logic [DIV_W-1:0] DIV_RST   = 16'h00FF
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic             start, eng_busy, eng_done, rise, fall;
    cmd_t             cmd;
    rsp_t             rsp;
    logic [DIV_W-1:0] div;

    mgmt_mdio_regs #(.ADDR_W(ADDR_W), .DIV_RST(DIV_RST)) regs_i (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .rdata(bus_rdata), .done(eng_done), .rsp(rsp), .start(start),
        .cmd(cmd), .div(div)
    );

    mgmt_mdio_clkgen clkgen_i (
        .clk(clk), .rst(rst), .start(start), .run(eng_busy), .div_in(div),
        .mdc(mdc), .rise(rise), .fall(fall)
    );

    mgmt_mdio_engine #(.PRE_LEN(PRE_LEN), .YIELD_LEN(YIELD_LEN)) engine_i (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .rise(rise),
        .fall(fall), .mdio_i(mdio_i), .busy(eng_busy), .done(eng_done),
        .rsp(rsp), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    AST_MDC_QUIET: assert property (@(posedge clk) disable iff (rst)
        !eng_busy |-> !mdc);                                      // R3

endmodule

// File: tb/mgmt_mdio_master_tb_top.sv
module mgmt_mdio_master_tb_top;
    localparam int PRE = 32;
    localparam int TOT = 88;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;
    logic        phy_val = 1'b1;
    bit          phy_present = 1'b0;
    logic [15:0] phy_data = '0;

    int checks = 0;
    int errors = 0;
    int rc = 0;
    logic  rec_oe [0:127];
    logic  rec_o  [0:127];
    longint rise_t [0:127];

    always #2 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : phy_val;

    mgmt_mdio_master dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: record master's bit at each rising edge, drive on falling edge
    always @(posedge mdc) begin
        if (rc < 128) begin
            rec_oe[rc] = mdio_oe;
            rec_o[rc]  = mdio_o;
            rise_t[rc] = $time;
        end
        rc = rc + 1;
    end

    always @(negedge mdc) begin
        if (phy_present && rc == PRE + 15)
            phy_val = 1'b0;
        else if (phy_present && rc >= PRE + 16 && rc <= PRE + 31)
            phy_val = phy_data[PRE + 31 - rc];
        else
            phy_val = 1'b1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    // mode 0: plain, 1: intrude on command word and divider, 2: disable mid-transfer
    task automatic do_frame(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] dat, input int div, input bit pres, input int mode);
        int P, n, bad4, bad5, badp;
        logic [31:0] ef, v, exp;
        P = (div == 0) ? 2 : div + 1;
        bus_write(2'd0, {2'b01, 14'b0, 16'(div)});
        phy_present = pres;
        phy_data = dat;
        rc = 0;
        bus_write(2'd1, {1'b1, wr, 1'b0, 3'b0, rg, phy, dat});
        bus_addr = 2'd1;
        n = 0;
        while (1) begin
            @(negedge clk);
            n++;
            if (bus_addr == 2'd1 && bus_rdata[31] == 1'b0) break;
            if (n > 3000) break;
            if (mode == 2 && n == 51)
                check(bus_rdata[31] == 1'b0, "R10 idle low in flight", bus_rdata, {1'b0, bus_rdata[30:0]});
            bus_we = 1'b0;
            bus_addr = 2'd1;
            if (mode == 1 && n == 40) begin
                bus_we = 1'b1;
                bus_wdata = {1'b1, ~wr, 1'b0, 3'b0, ~rg, ~phy, ~dat};
            end
            if (mode == 1 && n == 41) begin
                bus_we = 1'b1; bus_addr = 2'd0;
                bus_wdata = {2'b01, 14'b0, 16'd7};
            end
            if (mode == 2 && n == 40) begin
                bus_we = 1'b1; bus_addr = 2'd0;
                bus_wdata = {2'b00, 14'b0, 16'(div)};
            end
            if (mode == 2 && n == 50) bus_addr = 2'd0;
        end
        bus_we = 1'b0;
        check(n == TOT * P + 1, "R6 completion cycle", n, TOT * P + 1);
        check(rc == TOT, "R6 rising edge count", rc, TOT);
        badp = 0;
        for (int k = 1; k < TOT; k++)
            if (rise_t[k] - rise_t[k-1] != longint'(P * 4)) badp++;
        check(badp == 0, "R3 clock period", badp, 0);
        ef = {2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, dat};
        bad4 = 0; bad5 = 0;
        for (int k = 0; k < TOT; k++) begin
            if (k < PRE) begin
                if (rec_oe[k] !== 1'b1 || rec_o[k] !== 1'b1) bad4++;
            end else if (k < PRE + 32) begin
                if (!wr && (k - PRE) >= 14) begin
                    if (rec_oe[k] !== 1'b0) bad5++;
                end else if (rec_oe[k] !== 1'b1 || rec_o[k] !== ef[31 - (k - PRE)]) bad4++;
            end else if (rec_oe[k] !== 1'b0) bad5++;
        end
        check(bad4 == 0, "R4 driven bits", bad4, 0);
        check(bad5 == 0, wr ? "R9 release in trailing periods" : "R5 release on read", bad5, 0);
        bus_read(2'd1, v);
        if (wr) exp = {1'b0, 1'b1, 1'b0, 3'b0, rg, phy, dat};
        else    exp = {1'b0, 1'b0, pres, 3'b0, rg, phy, (pres ? dat : 16'hFFFF)};
        check(v == exp, wr ? (mode == 1 ? "R8 write fields kept" : "R9 write result")
                           : (mode == 1 ? "R8 read fields kept" : "R5 read result"), v, exp);
        if (mode == 2) begin
            bus_read(2'd0, v);
            exp = {1'b1, 1'b0, 14'b0, 16'(div)};
            check(v == exp, "R10 idle after finish", v, exp);
        end
    endtask

    initial begin
        #800000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        bus_read(2'd0, v);
        check(v == 32'h8000_00FF, "R1 control reset", v, 32'h8000_00FF);
        bus_read(2'd1, v);
        check(v == 32'h0, "R1 command reset", v, 32'h0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins idle", {mdc, mdio_oe}, 0);
        // R2
        bus_write(2'd0, 32'h4000_1234);
        bus_read(2'd0, v);
        check(v == 32'h4000_1234, "R2 control readback", v, 32'h4000_1234);
        bus_write(2'd0, 32'hC000_0003);
        bus_read(2'd0, v);
        check(v == 32'h4000_0003, "R2 idle not writable", v, 32'h4000_0003);
        // R7
        bus_write(2'd0, 32'h0000_0001);
        rc = 0;
        bus_write(2'd1, {1'b1, 1'b1, 1'b0, 3'b0, 5'd9, 5'd5, 16'hBEEF});
        repeat (100) @(negedge clk);
        check(rc == 0, "R7 no clock when disabled", rc, 0);
        bus_read(2'd1, v);
        exp = {1'b0, 1'b1, 1'b0, 3'b0, 5'd9, 5'd5, 16'hBEEF};
        check(v == exp, "R7 fields stored, GO clear", v, exp);
        bus_read(2'd0, v);
        check(v == 32'h8000_0001, "R7 still idle", v, 32'h8000_0001);
        // sweep dividers, directions, PHY presence
        for (int d = 0; d < 6; d++) begin
            for (int t = 0; t < 3; t++) begin
                do_frame(t == 0, 5'((d * 7 + 3 + t) & 31), 5'((d * 11 + t * 5 + 1) & 31),
                         16'hA5C3 ^ 16'(d * 16'h1111 + t), d, t != 2, 0);
            end
        end
        // field extremes
        do_frame(1'b0, 5'd31, 5'd31, 16'hFFFF, 1, 1'b1, 0);
        do_frame(1'b1, 5'd0, 5'd0, 16'h0000, 1, 1'b1, 0);
        do_frame(1'b0, 5'd0, 5'd0, 16'h0001, 1, 1'b1, 0);
        // R8 and divider capture (R3)
        do_frame(1'b0, 5'd12, 5'd3, 16'h5A5A, 2, 1'b1, 1);
        do_frame(1'b1, 5'd17, 5'd28, 16'h1357, 3, 1'b1, 1);
        // R10
        do_frame(1'b0, 5'd6, 5'd22, 16'h9ABC, 2, 1'b1, 2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule